// File: doc/BRIEF.md
# Burst-Four Wide-Word SRAM Core

This block is a synchronous memory core. Its data bus is one beat wide, and every transfer is a burst of four beats. Inside, the array is four beats wide. One command moves a whole wide word at once: a write is collected beat by beat and then stored in a single operation, and a read fetches the word once and hands it out one beat per cycle.

A command carries three things: a load strobe, a read/write select and a byte address. The upper address bits pick the wide word. In wide mode the two lowest bits pick the lane that travels first, and the burst then wraps through the remaining lanes in increasing order, modulo four. In narrow mode those two bits are ignored and every burst starts at lane 0.

Writes are late. A finished write stays in a pending buffer until the next write burst completes, and only then reaches the array. Reads look through that buffer byte by byte, so they always return the newest data. A new command can be taken at most once every four cycles.

Top module: `burst4_sram`

## Requirements
- R1: A read accepted in cycle t raises `rvalid_o` in cycles t+2, t+3, t+4 and t+5, one beat per cycle, so every read is exactly four beats.
- R2: `cmd_ready_o` is high in a cycle only if no command was accepted in the three cycles before it. A command is accepted when `cmd_ld_i` and `cmd_ready_o` are both high. A load while `cmd_ready_o` is low is ignored.
- R3: In wide mode (`cmd_narrow_i`=0), beat k of a read carries lane (addr[1:0]+k) mod 4 of word addr[7:2]. Lane j occupies bits j*18 .. j*18+17 of the wide word.
- R4: In narrow mode (`cmd_narrow_i`=1), addr[1:0] is ignored and beat k carries lane k, for both reads and writes.
- R5: A write accepted in cycle t takes its beats from `wdata_i`/`wbe_i` in cycles t+1 to t+4. Beat k goes to lane (start+k) mod 4, where start is addr[1:0] in wide mode and 0 in narrow mode.
- R6: `wbe_i[0]` gates bits 8:0 of a beat and `wbe_i[1]` gates bits 17:9. A field whose enable is 0 keeps its old value.
- R7: A read accepted in or after the cycle of a write's last beat returns that write's data, merged byte by byte with the older contents, even though the write is not yet in the array.
- R8: A pending write is committed to the array when the next write burst completes. Its data stays readable after any number of later writes to other words.
- R9: While `rst_ni` is low, `cmd_ready_o`=1, `rvalid_o`=0 and `rdata_o`=0. Reset discards an uncommitted write, and array contents already committed survive it.
- R10: `rdata_o` is zero in every cycle where `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_ld_i | input | 1 | Command load strobe |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_narrow_i | input | 1 | 1 = burst always starts at lane 0 |
| cmd_addr_i | input | 8 | Word index in bits 7:2, start lane in bits 1:0 |
| cmd_ready_o | output | 1 | A command can be accepted this cycle |
| wdata_i | input | 18 | Write beat |
| wbe_i | input | 2 | Per-beat byte enables |
| rdata_o | output | 18 | Read beat |
| rvalid_o | output | 1 | Read beat valid |

## Verification
Directed bursts use all four start lanes on the same word. This shows whether the wrap order is right, as opposed to plain linear or reversed order. Narrow-mode commands with non-zero low address bits show whether the start selection is actually turned off. Mixed byte-enable patterns separate per-field merging from whole-beat writes. A write followed at once by a read of the same word, and a write-write-read chain, tell the coherent bypass apart from the late commit. Constrained random traffic, with random modes, enables and idle gaps, then runs against a word-level model kept in the bench. A reset taken while a write is still pending confirms that the write is dropped and the committed data is kept.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  localparam int unsigned LANES = 4;

  typedef logic [1:0] lane_t;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // lane carried by beat k of a burst starting at lane s (wraps mod 4)
  function automatic lane_t lane_of(lane_t s, lane_t k);
    return lane_t'(s + k);
  endfunction
endpackage

// File: rtl/burst4_ctrl.sv
module burst4_ctrl
  import burst4_pkg::*;
#(
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              wr_i,
  input  logic              narrow_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              wr_start_o,
  output logic              rd_start_o,
  output lane_t             lane_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [1:0] gap_q;
  logic       acc;
  op_e        op;

  assign ready_o    = (gap_q == 2'd0);
  assign acc        = ld_i & ready_o;
  assign op         = op_e'(wr_i);
  assign wr_start_o = acc && (op == OP_WRITE);
  assign rd_start_o = acc && (op == OP_READ);
  assign lane_o     = narrow_i ? lane_t'(0) : addr_i[1:0];
  assign idx_o      = addr_i[ADDR_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= 2'd0;
    else if (acc)          gap_q <= 2'd3;
    else if (gap_q != 2'd0) gap_q <= gap_q - 2'd1;
  end

  AST_CMD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ready_o); // R2
  AST_SLOT_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc, 4) && !$past(acc, 3) && !$past(acc, 2) && !$past(acc, 1) |-> ready_o); // R2
endmodule

// File: rtl/burst4_wr_demux.sv
module burst4_wr_demux
  import burst4_pkg::*;
#(
  parameter int unsigned BW    = 18,
  parameter int unsigned NBE   = 2,
  parameter int unsigned IDX_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  lane_t                       lane_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [BW-1:0]               wdata_i,
  input  logic [NBE-1:0]              wbe_i,
  output logic                        pend_v_o,
  output logic [IDX_W-1:0]            pend_idx_o,
  output logic [LANES-1:0][BW-1:0]    pend_data_o,
  output logic [LANES-1:0][NBE-1:0]   pend_be_o,
  output logic                        commit_o
);
  logic                      col_act_q;
  logic [1:0]                col_cnt_q;
  lane_t                     col_lane_q;
  logic [IDX_W-1:0]          col_idx_q;
  logic [LANES-1:0][BW-1:0]  col_data_q, col_data_nx;
  logic [LANES-1:0][NBE-1:0] col_be_q, col_be_nx;
  logic                      last;

  assign last = col_act_q && (col_cnt_q == 2'd3);
  // old pending word goes to the array on the edge the new one completes
  assign commit_o = last && pend_v_o;

  always_comb begin
    col_data_nx = col_data_q;
    col_be_nx   = col_be_q;
    if (col_act_q) begin
      col_data_nx[col_lane_q] = wdata_i;
      col_be_nx[col_lane_q]   = wbe_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_act_q   <= 1'b0;
      col_cnt_q   <= 2'd0;
      col_lane_q  <= '0;
      col_idx_q   <= '0;
      col_data_q  <= '0;
      col_be_q    <= '0;
      pend_v_o    <= 1'b0;
      pend_idx_o  <= '0;
      pend_data_o <= '0;
      pend_be_o   <= '0;
    end else begin
      if (col_act_q) begin
        col_data_q <= col_data_nx;
        col_be_q   <= col_be_nx;
        col_lane_q <= lane_of(col_lane_q, 2'd1);
        col_cnt_q  <= col_cnt_q + 2'd1;
        if (last) begin
          col_act_q   <= 1'b0;
          pend_v_o    <= 1'b1;
          pend_idx_o  <= col_idx_q;
          pend_data_o <= col_data_nx;
          pend_be_o   <= col_be_nx;
        end
      end
      if (start_i) begin
        col_act_q  <= 1'b1;
        col_cnt_q  <= 2'd0;
        col_lane_q <= lane_i;
        col_idx_q  <= idx_i;
        col_be_q   <= '0;
      end
    end
  end

  AST_START_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!col_act_q || last)); // R2
  AST_PEND_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> pend_v_o); // R8
endmodule

// File: rtl/burst4_array.sv
module burst4_array
  import burst4_pkg::*;
#(
  parameter int unsigned BW    = 18,
  parameter int unsigned NBE   = 2,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned FW    = BW / NBE
) (
  input  logic                        clk_i,
  input  logic                        commit_i,
  input  logic                        pend_v_i,
  input  logic [IDX_W-1:0]            pend_idx_i,
  input  logic [LANES-1:0][BW-1:0]    pend_data_i,
  input  logic [LANES-1:0][NBE-1:0]   pend_be_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [LANES-1:0][BW-1:0]    rd_word_o
);
  logic [LANES-1:0][BW-1:0] mem_q [DEPTH];
  logic                     hit;

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int l = 0; l < LANES; l++) begin
        for (int b = 0; b < NBE; b++) begin
          if (pend_be_i[l][b]) mem_q[pend_idx_i][l][b*FW +: FW] <= pend_data_i[l][b*FW +: FW];
        end
      end
    end
  end

  // coherent read: pending bytes override array bytes
  assign hit = pend_v_i && (pend_idx_i == rd_idx_i);
  always_comb begin
    rd_word_o = mem_q[rd_idx_i];
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < NBE; b++) begin
        if (hit && pend_be_i[l][b]) rd_word_o[l][b*FW +: FW] = pend_data_i[l][b*FW +: FW];
      end
    end
  end
endmodule

// File: rtl/burst4_rd_mux.sv
module burst4_rd_mux
  import burst4_pkg::*;
#(
  parameter int unsigned BW    = 18,
  parameter int unsigned IDX_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  lane_t                     lane_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [IDX_W-1:0]          rd_idx_o,
  input  logic [LANES-1:0][BW-1:0]  rd_word_i,
  output logic [BW-1:0]             rdata_o,
  output logic                      rvalid_o
);
  logic                     rq_v_q;
  lane_t                    rq_lane_q;
  logic [LANES-1:0][BW-1:0] word_q;
  lane_t                    ptr_q;
  logic [1:0]               cnt_q;
  logic                     act_q;

  assign rd_idx_o = rd_idx_q;
  assign rvalid_o = act_q;
  assign rdata_o  = act_q ? word_q[ptr_q] : '0;

  logic [IDX_W-1:0] rd_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v_q    <= 1'b0;
      rq_lane_q <= '0;
      rd_idx_q  <= '0;
      word_q    <= '0;
      ptr_q     <= '0;
      cnt_q     <= 2'd0;
      act_q     <= 1'b0;
    end else begin
      rq_v_q <= start_i;
      if (start_i) begin
        rq_lane_q <= lane_i;
        rd_idx_q  <= idx_i;
      end
      if (rq_v_q) begin
        word_q <= rd_word_i;
        ptr_q  <= rq_lane_q;
        cnt_q  <= 2'd0;
        act_q  <= 1'b1;
      end else if (act_q) begin
        ptr_q <= lane_of(ptr_q, 2'd1);
        cnt_q <= cnt_q + 2'd1;
        if (cnt_q == 2'd3) act_q <= 1'b0;
      end
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i, 2) |-> rvalid_o); // R1
  AST_BURST_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rvalid_o) |-> $past(cnt_q) == 2'd3); // R1
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
  import burst4_pkg::*;
#(
  parameter int unsigned BEAT_W = 18,
  parameter int unsigned BE_N   = 2,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_ld_i,
  input  logic              cmd_wr_i,
  input  logic              cmd_narrow_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              cmd_ready_o,
  input  logic [BEAT_W-1:0] wdata_i,
  input  logic [BE_N-1:0]   wbe_i,
  output logic [BEAT_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic                          wr_start, rd_start, pend_v, commit;
  lane_t                         lane;
  logic [IDX_W-1:0]              idx, pend_idx, rd_idx;
  logic [LANES-1:0][BEAT_W-1:0]  pend_data, rd_word;
  logic [LANES-1:0][BE_N-1:0]    pend_be;

  burst4_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .ld_i(cmd_ld_i), .wr_i(cmd_wr_i), .narrow_i(cmd_narrow_i), .addr_i(cmd_addr_i),
    .ready_o(cmd_ready_o), .wr_start_o(wr_start), .rd_start_o(rd_start),
    .lane_o(lane), .idx_o(idx)
  );

  burst4_wr_demux #(.BW(BEAT_W), .NBE(BE_N), .IDX_W(IDX_W)) u_wr (
    .clk_i, .rst_ni,
    .start_i(wr_start), .lane_i(lane), .idx_i(idx),
    .wdata_i, .wbe_i,
    .pend_v_o(pend_v), .pend_idx_o(pend_idx), .pend_data_o(pend_data),
    .pend_be_o(pend_be), .commit_o(commit)
  );

  burst4_array #(.BW(BEAT_W), .NBE(BE_N), .DEPTH(DEPTH)) u_array (
    .clk_i,
    .commit_i(commit), .pend_v_i(pend_v), .pend_idx_i(pend_idx),
    .pend_data_i(pend_data), .pend_be_i(pend_be),
    .rd_idx_i(rd_idx), .rd_word_o(rd_word)
  );

  burst4_rd_mux #(.BW(BEAT_W), .IDX_W(IDX_W)) u_rd (
    .clk_i, .rst_ni,
    .start_i(rd_start), .lane_i(lane), .idx_i(idx),
    .rd_idx_o(rd_idx), .rd_word_i(rd_word),
    .rdata_o, .rvalid_o
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0); // R10
endmodule

// File: tb/burst4_sram_bench.sv
module burst4_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 18;
  localparam int NBE = 2;
  localparam int FW = BW / NBE;
  localparam int DEPTH = 64;

  typedef logic [3:0][BW-1:0]  word_t;
  typedef logic [3:0][NBE-1:0] be4_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld = 1'b0, wr = 1'b0, nar = 1'b0;
  logic [7:0]    addr = '0;
  logic          ready;
  logic [BW-1:0] wdata = '0;
  logic [NBE-1:0] wbe = '0;
  logic [BW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  word_t mdl [DEPTH];
  word_t saved_word;
  int    saved_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst4_sram u_burst4_sram (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_ld_i(ld), .cmd_wr_i(wr), .cmd_narrow_i(nar), .cmd_addr_i(addr),
    .cmd_ready_o(ready), .wdata_i(wdata), .wbe_i(wbe),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [1:0] exp_lane(logic [1:0] s, int k);
    return 2'(int'(s) + k);
  endfunction

  function automatic logic [1:0] start_of(logic [7:0] a, bit n);
    return n ? 2'd0 : a[1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle t: command; beats in t+1..t+4; returns in cycle t+4
  task automatic do_write(input logic [7:0] a, input bit n, input word_t beats, input be4_t be);
    int idx = int'(a[7:2]);
    logic [1:0] s = start_of(a, n);
    chk(ready === 1'b1, "R2", 32'(ready), 32'd1);
    saved_idx  = idx;
    saved_word = mdl[idx];
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < NBE; b++)
        if (be[k][b]) mdl[idx][exp_lane(s, k)][b*FW +: FW] = beats[k][b*FW +: FW];
    ld = 1'b1; wr = 1'b1; nar = n; addr = a;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ld = 1'b0;
      wdata = beats[k];
      wbe = be[k];
    end
  endtask

  // cycle t: command; beats checked in t+2..t+5; returns in cycle t+5
  task automatic do_read(input logic [7:0] a, input bit n, input string req, input bit poke);
    int idx = int'(a[7:2]);
    logic [1:0] s = start_of(a, n);
    word_t w = mdl[idx];
    chk(ready === 1'b1, "R2", 32'(ready), 32'd1);
    ld = 1'b1; wr = 1'b0; nar = n; addr = a;
    @(negedge clk);
    if (poke) begin
      ld = 1'b1; wr = 1'b1; addr = 8'hFC; wdata = '1; wbe = '1;
    end else ld = 1'b0;
    chk(ready === 1'b0, "R2", 32'(ready), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 2) begin
        ld = 1'b0;
        chk(ready === 1'b1, "R2", 32'(ready), 32'd1);
      end
      chk(rvalid === 1'b1, "R1", 32'(rvalid), 32'd1);
      chk(rdata === w[exp_lane(s, k)], req, 32'(rdata), 32'(w[exp_lane(s, k)]));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ld = 1'b0;
    chk(rvalid === 1'b0, "R10", 32'(rvalid), 32'd0);
    chk(rdata === '0, "R10", 32'(rdata), 32'd0);
  endtask

  function automatic word_t rnd_word();
    word_t w;
    for (int k = 0; k < 4; k++) w[k] = BW'($urandom);
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    word_t w;
    be4_t  e;
    int    seed_v;
    seed_v = int'($urandom(32'h5EED_0042));
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(ready === 1'b1, "R9", 32'(ready), 32'd1);
    chk(rvalid === 1'b0, "R9", 32'(rvalid), 32'd0);
    chk(rdata === '0, "R9", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill every word with full-enable writes
    for (int i = 0; i < DEPTH; i++) do_write(8'(i << 2), 1'b0, rnd_word(), '1);
    idle();

    // R5 / R3: write starting at lane 2, read from every start lane
    w = {18'h3_0303, 18'h2_0202, 18'h1_0101, 18'h0_0000};
    do_write({6'd5, 2'd2}, 1'b0, w, '1);
    idle();
    for (int s = 0; s < 4; s++) do_read({6'd5, 2'(s)}, 1'b0, "R3", 1'b0);
    do_read({6'd5, 2'd1}, 1'b0, "R5", 1'b0);

    // R4: narrow mode ignores low address bits
    do_write({6'd9, 2'd3}, 1'b1, rnd_word(), '1);
    do_read({6'd9, 2'd2}, 1'b1, "R4", 1'b0);
    do_read({6'd9, 2'd0}, 1'b0, "R4", 1'b0);

    // R6: byte enable patterns
    e = {2'b11, 2'b00, 2'b10, 2'b01};
    do_write({6'd12, 2'd0}, 1'b0, rnd_word(), e);
    idle();
    do_read({6'd12, 2'd0}, 1'b0, "R6", 1'b0);

    // R7: read right at the last write beat, partial enables
    do_write({6'd20, 2'd3}, 1'b0, rnd_word(), {2'b01, 2'b10, 2'b11, 2'b00});
    do_read({6'd20, 2'd1}, 1'b0, "R7", 1'b0);

    // R8: commit by a later write, then more writes elsewhere
    do_write({6'd30, 2'd0}, 1'b0, rnd_word(), {2'b10, 2'b01, 2'b10, 2'b01});
    do_write({6'd31, 2'd0}, 1'b0, rnd_word(), '1);
    do_write({6'd32, 2'd2}, 1'b0, rnd_word(), '1);
    idle();
    do_read({6'd30, 2'd0}, 1'b0, "R8", 1'b0);

    // R2: loads while busy are ignored (poke targets word 63)
    do_read({6'd31, 2'd1}, 1'b0, "R2", 1'b1);
    idle();
    do_read({6'd63, 2'd0}, 1'b0, "R2", 1'b0);

    // R9: reset drops the pending write, keeps committed data
    do_write({6'd40, 2'd0}, 1'b0, rnd_word(), '1);
    do_write({6'd41, 2'd0}, 1'b0, rnd_word(), '1);
    do_write({6'd40, 2'd1}, 1'b0, rnd_word(), '1);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready === 1'b1, "R9", 32'(ready), 32'd1);
    chk(rvalid === 1'b0, "R9", 32'(rvalid), 32'd0);
    mdl[saved_idx] = saved_word;
    rst_n = 1'b1;
    @(negedge clk);
    do_read({6'd40, 2'd0}, 1'b0, "R9", 1'b0);
    do_read({6'd41, 2'd2}, 1'b0, "R9", 1'b0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(9, 0));
      logic [7:0] a = 8'($urandom);
      bit n = ($urandom_range(3, 0) == 0);
      if (r < 4) begin
        for (int k = 0; k < 4; k++) e[k] = NBE'($urandom);
        do_write(a, n, rnd_word(), e);
      end else if (r < 8) begin
        do_read(a, n, n ? "R4" : "R7", 1'b0);
      end else begin
        idle();
      end
    end
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule